// File: doc/BRIEF.md
# Processor-Mapped Serial Port Core

This core gives a simple processor a byte-wide serial port. The processor reaches it through a chip select, a read/write-bar strobe, a 2-bit register address and one shared 8-bit bidirectional data bus. Writing a byte to the transmit register starts a frame on `txd`. A byte that arrives on `rxd` is collected by an internal 16x oversampling receiver and held until the processor reads it. Two handshake outputs report the state of each side: `tx_ready` is high when the transmitter can take a byte, and `rx_avail` is high when a received byte is waiting to be read.

The bit rate comes from a 16-bit divisor register that the processor can load at any time. The divisor divides the system clock into a one-cycle enable at 16 times the bit rate. One clock can therefore serve several bit rates, such as 4800 and 9600 bit/s, and only the divisor value changes between them. A frame has a low start bit, eight data bits sent least significant first, an optional parity bit and one high stop bit. Two static configuration inputs choose the parity mode.

Top module: `serport_core`

## Requirements
- R1: The core drives `data` only while `cs`=1 and `rw_n`=1. A register write happens at a rising clock edge when `cs`=1 and `rw_n`=0, and it takes the value that is on `data`.
- R2: Register map by `addr`. Address 0 writes the transmit byte and reads the received byte. Address 1 reads status, with bit 0 = `tx_ready`, bit 1 = `rx_avail` and the other bits 0. Address 2 writes the low byte of the divisor and address 3 writes the high byte. Reads of addresses 2 and 3 return 0.
- R3: With divisor value D, the enable fires once every D+1 clocks and a bit lasts 16 enables, so a bit lasts 16*(D+1) clocks. A divisor write reloads the enable counter at once. Changing only D changes the bit rate (D=3 gives 64 clocks per bit and D=1 gives 32).
- R4: A transmitted frame is a start bit (0), then data bits 0 to 7 in that order, then the parity bit when parity is enabled, then a stop bit (1).
- R5: `par_mode` selects parity: 00 = none, 01 = even (parity bit = XOR of the data bits), 10 = odd (parity bit = inverted XOR), 11 = none. The receiver uses the same mode.
- R6: `tx_ready` is 1 after reset. It goes to 0 on the edge that accepts a transmit write. It returns to 1 only after the full stop bit has been sent. A transmit write made while `tx_ready`=0 is ignored.
- R7: `txd` stays 1 whenever no frame is in progress.
- R8: `rx_avail` is 0 after reset. It goes to 1 when a valid frame has been received, and the byte can then be read at address 0. A read of address 0 clears `rx_avail`.
- R9: `rxd` passes through a two-flop synchronizer. A low level counts as a start bit only if it is still low at the middle of the start bit; a shorter low pulse is ignored.
- R10: A received frame with a low stop bit, or with a parity bit that does not match the selected mode, is discarded and `rx_avail` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| rw_n | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Register select |
| data | inout | 8 | Bidirectional processor data bus |
| par_mode | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 none |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_avail | output | 1 | Received byte waiting |

## Verification
The hardest case to reach is the receiver's handling of line noise and bad frames. It has to reject a low pulse shorter than half a bit, and it has to discard frames whose stop or parity bit is wrong, without leaving stale state behind. The receive driver builds each frame bit by bit at the bench's own bit period, and it can flip the parity bit or force the stop bit low on request. A separate step drives only a quarter-bit low pulse. After each of these cases, a clean frame confirms that the receiver has returned to idle. On the transmit side, a second write is issued while a frame is in progress. The scoreboard then shows that no extra frame appears, and it samples the line at bit centres under two divisor values.

// File: rtl/serport_core.sv
module serport_core #(
  parameter logic [15:0] DIV_INIT = 16'd3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rw_n,
  input  logic [1:0] addr,
  inout  wire  [7:0] data,
  input  logic [1:0] par_mode,
  input  logic       rxd,
  output logic       txd,
  output logic       tx_ready,
  output logic       rx_avail
);

  localparam int OVS      = 16;
  localparam int TW       = $clog2(OVS);
  localparam logic [TW-1:0] TICK_LAST = TW'(OVS - 1);
  localparam logic [TW-1:0] TICK_MID  = TW'(OVS / 2 - 1);

  logic wr, rd, par_on, par_odd;
  assign wr      = cs & ~rw_n;
  assign rd      = cs & rw_n;
  assign par_on  = (par_mode == 2'b01) || (par_mode == 2'b10);
  assign par_odd = (par_mode == 2'b10);

  logic [15:0] div_q, cnt_q;
  logic        en;
  assign en = (cnt_q == 16'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_INIT;
      cnt_q <= DIV_INIT;
    end else if (wr && addr == 2'd2) begin
      div_q[7:0] <= data;
      cnt_q      <= {div_q[15:8], data};
    end else if (wr && addr == 2'd3) begin
      div_q[15:8] <= data;
      cnt_q       <= {data, div_q[7:0]};
    end else if (en) begin
      cnt_q <= div_q;
    end else begin
      cnt_q <= cnt_q - 16'd1;
    end
  end

  logic [10:0]   tx_sh;
  logic [TW-1:0] tx_tick;
  logic [3:0]    tx_left;
  assign txd = tx_ready | tx_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ready <= 1'b1;
      tx_sh    <= '1;
      tx_tick  <= '0;
      tx_left  <= '0;
    end else if (wr && addr == 2'd0 && tx_ready) begin
      tx_ready <= 1'b0;
      tx_tick  <= '0;
      if (par_on) begin
        tx_sh   <= {1'b1, ^data ^ par_odd, data, 1'b0};
        tx_left <= 4'd11;
      end else begin
        tx_sh   <= {2'b11, data, 1'b0};
        tx_left <= 4'd10;
      end
    end else if (!tx_ready && en) begin
      tx_tick <= tx_tick + 1'b1;
      if (tx_tick == TICK_LAST) begin
        tx_sh   <= {1'b1, tx_sh[10:1]};
        tx_left <= tx_left - 4'd1;
        if (tx_left == 4'd1) tx_ready <= 1'b1;
      end
    end
  end

  logic [1:0]    rx_sync;
  logic          rx_s, rx_on, par_ok;
  logic [TW-1:0] rx_tick;
  logic [3:0]    rx_idx;
  logic [7:0]    rx_sh, rx_buf;
  assign rx_s = rx_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync  <= 2'b11;
      rx_on    <= 1'b0;
      par_ok   <= 1'b1;
      rx_tick  <= '0;
      rx_idx   <= '0;
      rx_sh    <= '0;
      rx_buf   <= '0;
      rx_avail <= 1'b0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      if (rd && addr == 2'd0) rx_avail <= 1'b0;
      if (en) begin
        if (!rx_on) begin
          if (!rx_s) begin
            rx_on   <= 1'b1;
            rx_tick <= '0;
            rx_idx  <= '0;
            par_ok  <= 1'b1;
          end
        end else begin
          rx_tick <= rx_tick + 1'b1;
          if (rx_tick == TICK_MID) begin
            rx_idx <= rx_idx + 4'd1;
            if (rx_idx == 4'd0) begin
              if (rx_s) rx_on <= 1'b0;
            end else if (rx_idx <= 4'd8) begin
              rx_sh <= {rx_s, rx_sh[7:1]};
            end else if (rx_idx == 4'd9 && par_on) begin
              par_ok <= ((^rx_sh) ^ rx_s) == par_odd;
            end else begin
              rx_on <= 1'b0;
              if (rx_s && par_ok) begin
                rx_buf   <= rx_sh;
                rx_avail <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

  logic [7:0] rd_val;
  always_comb begin
    case (addr)
      2'd0:    rd_val = rx_buf;
      2'd1:    rd_val = {6'd0, rx_avail, tx_ready};
      default: rd_val = 8'd0;
    endcase
  end
  assign data = rd ? rd_val : 8'bz;

endmodule

// File: rtl/serport_core_chk.sv
module serport_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       rw_n,
  input logic [1:0] addr,
  input logic       txd,
  input logic       tx_ready,
  input logic       rx_avail
);

  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  a_r6_tbr_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(cs && !rw_n && addr == 2'd0));

  a_r6_tbr_set_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(txd));

  a_r8_rda_clear_by_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_avail) |-> $past(cs && rw_n && addr == 2'd0));

  a_r6_write_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !rw_n && addr == 2'd0 && tx_ready) |=> !tx_ready);

endmodule

bind serport_core serport_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rw_n(rw_n), .addr(addr),
  .txd(txd), .tx_ready(tx_ready), .rx_avail(rx_avail)
);

// File: tb/serport_core_tb_top.sv
module serport_core_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, cs, rw_n, rxd, oe;
  logic [1:0] addr, par_mode;
  logic [7:0] drv, rv;
  wire  [7:0] data;
  wire        txd, tx_ready, rx_avail;
  assign data = oe ? drv : 8'bz;

  serport_core dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rw_n(rw_n), .addr(addr), .data(data),
    .par_mode(par_mode), .rxd(rxd), .txd(txd), .tx_ready(tx_ready), .rx_avail(rx_avail)
  );

  int checks = 0, fails = 0, bit_t = 64;
  bit done = 0;
  logic [9:0] txq[$];
  logic [7:0] rxq[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; rw_n = 0; addr = a; drv = d; oe = 1;
    @(negedge clk); cs = 0; oe = 0; rw_n = 1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rw_n = 1; addr = a; oe = 0;
    #1 d = data;
    @(negedge clk); cs = 0;
  endtask

  function automatic logic par_bit(input logic [7:0] b, input logic [1:0] m);
    return (m == 2'b10) ? ~^b : ^b;
  endfunction

  function automatic bit par_en(input logic [1:0] m);
    return m == 2'b01 || m == 2'b10;
  endfunction

  task automatic send_tx(input logic [7:0] b);
    txq.push_back({par_en(par_mode), par_bit(b, par_mode), b});
    bus_wr(2'd0, b);
  endtask

  task automatic wait_tx_done(input string req);
    while (!tx_ready) @(negedge clk);
    chk(txq.size() == 0, req, "frame seen before tx_ready", txq.size(), 0);
    chk(txd == 1'b1, "R7", "txd idle after frame", txd, 1);
  endtask

  task automatic send_rx(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    logic [11:0] f;
    int n;
    f = {1'b1, 1'b1, 1'b1, b, 1'b0};
    n = 10;
    if (par_en(par_mode)) begin
      f[9] = par_bit(b, par_mode) ^ bad_par;
      n = 11;
    end
    f[n-1] = ~bad_stop;
    if (!bad_par && !bad_stop) rxq.push_back(b);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (bit_t - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1;
    repeat (bit_t) @(negedge clk);
  endtask

  task automatic expect_rx(input string req);
    logic [7:0] e;
    chk(rx_avail == 1'b1, req, "rx_avail after frame", rx_avail, 1);
    bus_rd(2'd1, rv);
    chk(rv[1] == 1'b1, "R2", "status bit1 rx_avail", rv, 8'h03);
    bus_rd(2'd0, rv);
    e = (rxq.size() > 0) ? rxq.pop_front() : 8'hxx;
    chk(rv == e, req, "received byte", rv, e);
    @(negedge clk);
    chk(rx_avail == 1'b0, "R8", "rx_avail cleared by read", rx_avail, 0);
  endtask

  task automatic expect_drop(input string req);
    chk(rx_avail == 1'b0, req, "bad frame dropped", rx_avail, 0);
    void'(rxq.size());
  endtask

  initial begin
    logic [7:0] b;
    logic p, st, sp;
    logic [9:0] e;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        e = (txq.size() > 0) ? txq[0] : 10'd0;
        repeat (bit_t / 2) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin
          repeat (bit_t) @(negedge clk);
          b[i] = txd;
        end
        p = 1'b0;
        if (e[9]) begin
          repeat (bit_t) @(negedge clk);
          p = txd;
        end
        repeat (bit_t) @(negedge clk);
        sp = txd;
        if (txq.size() == 0) begin
          chk(0, "R6", "unexpected tx frame", b, 0);
        end else begin
          e = txq.pop_front();
          chk(st == 1'b0, "R4", "start bit", st, 0);
          chk(b == e[7:0], "R4", "tx data LSB first", b, e[7:0]);
          if (e[9]) chk(p == e[8], "R5", "tx parity bit", p, e[8]);
          chk(sp == 1'b1, "R4", "stop bit", sp, 1);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cs = 0; rw_n = 1; addr = 0; drv = 0; oe = 0; rxd = 1; par_mode = 2'b00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1'b1, "R7", "txd after reset", txd, 1);
    chk(tx_ready == 1'b1, "R6", "tx_ready after reset", tx_ready, 1);
    chk(rx_avail == 1'b0, "R8", "rx_avail after reset", rx_avail, 0);
    bus_rd(2'd1, rv);
    chk(rv == 8'h01, "R2", "status after reset", rv, 8'h01);
    bus_rd(2'd2, rv);
    chk(rv == 8'h00, "R2", "addr2 reads zero", rv, 0);

    bus_wr(2'd2, 8'd3); bus_wr(2'd3, 8'd0); bit_t = 64;
    send_tx(8'hA5);
    chk(tx_ready == 1'b0, "R6", "tx_ready cleared by write", tx_ready, 0);
    bus_rd(2'd1, rv);
    chk(rv == 8'h00, "R1", "status read while busy", rv, 8'h00);
    bus_wr(2'd0, 8'h3C);
    wait_tx_done("R6");
    repeat (2 * bit_t) @(negedge clk);
    chk(txd == 1'b1, "R6", "write while busy ignored", txd, 1);

    par_mode = 2'b01;
    send_tx(8'h07); wait_tx_done("R5");
    send_tx(8'h81); wait_tx_done("R5");
    par_mode = 2'b10;
    send_tx(8'h00); wait_tx_done("R5");
    par_mode = 2'b11;
    send_tx(8'hFF); wait_tx_done("R5");

    par_mode = 2'b00;
    bus_wr(2'd2, 8'd1); bit_t = 32;
    send_tx(8'h5A); wait_tx_done("R3");
    send_tx(8'hC3); wait_tx_done("R3");

    send_rx(8'h3C, 0, 0); expect_rx("R8");
    par_mode = 2'b01;
    send_rx(8'h96, 0, 0); expect_rx("R5");
    send_rx(8'h96, 1, 0); expect_drop("R10");
    par_mode = 2'b10;
    send_rx(8'h4B, 0, 0); expect_rx("R5");
    par_mode = 2'b00;
    send_rx(8'hE1, 0, 1); expect_drop("R10");
    send_rx(8'h11, 0, 0); expect_rx("R10");

    @(negedge clk); rxd = 0;
    repeat (bit_t / 4) @(negedge clk);
    rxd = 1;
    repeat (12 * bit_t) @(negedge clk);
    chk(rx_avail == 1'b0, "R9", "short low pulse ignored", rx_avail, 0);
    send_rx(8'h6E, 0, 0); expect_rx("R9");

    bus_wr(2'd2, 8'd3); bit_t = 64;
    send_rx(8'h82, 0, 0); expect_rx("R3");
    chk(txq.size() == 0 && rxq.size() == 0, "R4", "scoreboard drained", txq.size() + rxq.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule